// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous host and an external asynchronous static RAM of 262,144 words by 16 bits. The host issues one word at a time. Each request carries an 18-bit word address, a read or write flag, 16 bits of write data and one enable bit per byte. The handshake is ready/valid. The controller then walks the memory through its access. It drives the active-low chip enable, output enable, write enable and the two byte strobes, and it holds each phase for a cycle count that is worked out from nanosecond limits and the clock period.

A read keeps the output enable low for the access count. At the last access cycle it captures the bus and raises a one-cycle valid pulse. After that it waits out a release window before anything else may drive the bus. A write puts address, lanes and data on the pins one cycle before the write pulse and keeps them there one cycle after it. Output enable stays high for the whole write. The bidirectional data bus appears as separate out, in and per-lane drive-enable signals. Only the byte lanes the host selected are strobed, driven or returned.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and whenever `req_ready` is high, chip enable, output enable and write enable are all high and `mem_dq_oe` is 0. `rd_valid` is 0 after reset.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low for exactly N_RD+N_REL cycles after a read, or N_WP+2 cycles after a write.
- R3: A read holds chip enable and output enable low and write enable high for N_RD cycles. `rd_valid` is high for exactly one cycle, N_RD cycles after the accepting edge. It carries the bus value from the last access cycle.
- R4: Byte enable bit 0 selects the lower lane (data bits 7:0, strobe `mem_lb_n`). Bit 1 selects the upper lane (bits 15:8, strobe `mem_ub_n`). During a read only the selected lanes' strobes go low, and a lane that was not selected reads back as 8'h00.
- R5: After a read, chip enable and output enable are high and `mem_dq_oe` is 0 for N_REL cycles before the controller drives the bus.
- R6: A write has one setup cycle, then write enable low for exactly N_WP cycles, then one hold cycle. Output enable is high in all three phases.
- R7: During a write only the selected lanes have their strobe low and their drive enable high. A lane that was not selected keeps its stored contents.
- R8: `mem_addr`, `mem_dq_o` and the byte strobes equal the accepted request and do not change from the setup cycle through the hold cycle of a write. During a read `mem_addr` equals the accepted address.
- R9: Each phase count is the nanosecond limit divided by CLK_NS and rounded up, with a minimum of 1. The defaults are 70 ns, 50 ns and 40 ns at 10 ns, which give N_RD=7, N_WP=5 and N_REL=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 lower lane, bit 1 upper lane |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_dq_o | output | 16 | Data toward memory |
| mem_dq_i | input | 16 | Data from memory |
| mem_dq_oe | output | 2 | Per-lane drive enable for mem_dq_o |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |

## Verification
Every request is tied to the edge that accepts it. The read valid pulse is due N_RD edges after that edge, and `req_ready` returns N_RD+N_REL edges after a read or N_WP+2 edges after a write. The bench works out N_RD, N_WP and N_REL itself from the nanosecond limits and the clock period. The driver records the cycle number of each acceptance, and the monitor compares the cycle at which each result shows up against that number plus the expected count. All pins are sampled on the falling edge, after the registered controls have settled. The memory model checks write-pulse width, output enable during a write and overlap of the two drivers on every cycle.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_READ  = 3'd1,
    PH_REL   = 3'd2,
    PH_WSET  = 3'd3,
    PH_WPUL  = 3'd4,
    PH_WHOLD = 3'd5
  } phase_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic lanes_on;
    logic drive;
  } pin_ctl_t;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int cycles_for(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic pin_ctl_t ctl_of(input phase_e ph);
    pin_ctl_t c;
    c = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, lanes_on: 1'b0, drive: 1'b0};
    case (ph)
      PH_READ:  begin c.ce_n = 1'b0; c.oe_n = 1'b0; c.lanes_on = 1'b1; end
      PH_WSET,
      PH_WHOLD: begin c.ce_n = 1'b0; c.lanes_on = 1'b1; c.drive = 1'b1; end
      PH_WPUL:  begin c.ce_n = 1'b0; c.we_n = 1'b0; c.lanes_on = 1'b1; c.drive = 1'b1; end
      default:  ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         lanes_on,
  input  logic         drive,
  input  logic         capture,
  input  logic [W-1:0] din,
  output logic         strobe_n,
  output logic         drive_en,
  output logic [W-1:0] rbyte
);
  assign strobe_n = ~(lanes_on & sel);
  assign drive_en = drive & sel;

  always_ff @(posedge clk) begin
    if (!rst_n)       rbyte <= '0;
    else if (capture) rbyte <= sel ? din : '0;
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int LANES     = 2,
  parameter int CLK_NS    = 10,
  parameter int T_ACC_NS  = 70,
  parameter int T_WP_NS   = 50,
  parameter int T_REL_NS  = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [8*LANES-1:0]   req_wdata,
  input  logic [LANES-1:0]     req_be,
  output logic                 rd_valid,
  output logic [8*LANES-1:0]   rd_data,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [8*LANES-1:0]   mem_dq_o,
  input  logic [8*LANES-1:0]   mem_dq_i,
  output logic [LANES-1:0]     mem_dq_oe,
  output logic                 mem_ce_n,
  output logic                 mem_oe_n,
  output logic                 mem_we_n,
  output logic                 mem_lb_n,
  output logic                 mem_ub_n
);
  localparam int DATA_W = 8 * LANES;
  localparam int N_RD   = cycles_for(T_ACC_NS, CLK_NS);
  localparam int N_WP   = cycles_for(T_WP_NS, CLK_NS);
  localparam int N_REL  = cycles_for(T_REL_NS, CLK_NS);
  localparam int CNT_W  = $clog2(max3(N_RD, N_WP, N_REL) + 1);

  phase_e              state_q, state_d;
  pin_ctl_t            ctl_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [LANES-1:0]    be_q;
  logic [LANES-1:0]    strobe_n;
  logic                rd_valid_q;

  // named events for the checker
  logic                accept;
  logic                timer_expired;
  logic                timer_load;
  logic [CNT_W-1:0]    timer_val;
  logic                read_capture;

  assign req_ready    = (state_q == PH_IDLE);
  assign accept       = req_valid & req_ready;
  assign read_capture = (state_q == PH_READ) & timer_expired;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PH_IDLE:  if (req_valid) state_d = req_write ? PH_WSET : PH_READ;
      PH_READ:  if (timer_expired) state_d = PH_REL;
      PH_REL:   if (timer_expired) state_d = PH_IDLE;
      PH_WSET:  state_d = PH_WPUL;
      PH_WPUL:  if (timer_expired) state_d = PH_WHOLD;
      PH_WHOLD: state_d = PH_IDLE;
      default:  state_d = PH_IDLE;
    endcase
  end

  always_comb begin
    timer_load = (state_d != state_q);
    case (state_d)
      PH_READ: timer_val = CNT_W'(N_RD - 1);
      PH_REL:  timer_val = CNT_W'(N_REL - 1);
      PH_WPUL: timer_val = CNT_W'(N_WP - 1);
      default: begin timer_val = '0; timer_load = 1'b0; end
    endcase
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .expired  (timer_expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= PH_IDLE;
      ctl_q      <= ctl_of(PH_IDLE);
      addr_q     <= '0;
      wdata_q    <= '0;
      be_q       <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      ctl_q      <= ctl_of(state_d);
      rd_valid_q <= read_capture;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_byte_lane #(.W(8)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (be_q[g]),
      .lanes_on (ctl_q.lanes_on),
      .drive    (ctl_q.drive),
      .capture  (read_capture),
      .din      (mem_dq_i[8*g +: 8]),
      .strobe_n (strobe_n[g]),
      .drive_en (mem_dq_oe[g]),
      .rbyte    (rd_data[8*g +: 8])
    );
  end

  assign rd_valid = rd_valid_q;
  assign mem_addr = addr_q;
  assign mem_dq_o = wdata_q;
  assign mem_ce_n = ctl_q.ce_n;
  assign mem_oe_n = ctl_q.oe_n;
  assign mem_we_n = ctl_q.we_n;
  assign mem_lb_n = strobe_n[0];
  assign mem_ub_n = strobe_n[LANES-1];
endmodule

// File: rtl/sram_lane_chk.sv
module sram_lane_chk #(
  parameter int ADDR_W = 18,
  parameter int LANES  = 2,
  parameter int N_WP   = 5,
  parameter int N_REL  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_ready,
  input logic                req_valid,
  input logic                rd_valid,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [8*LANES-1:0]  mem_dq_o,
  input logic [LANES-1:0]    mem_dq_oe,
  input logic                mem_ce_n,
  input logic                mem_oe_n,
  input logic                mem_we_n,
  input logic                mem_lb_n,
  input logic                mem_ub_n
);
  logic        oe_prev;
  logic [7:0]  rel_cnt;
  logic [7:0]  low_cnt;
  logic        oe_rise;
  logic        rel_window;

  assign oe_rise    = mem_oe_n & ~oe_prev;
  assign rel_window = oe_rise | (rel_cnt != 8'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_prev <= 1'b1;
      rel_cnt <= 8'd0;
      low_cnt <= 8'd0;
    end else begin
      oe_prev <= mem_oe_n;
      if (oe_rise)              rel_cnt <= 8'(N_REL - 1);
      else if (rel_cnt != 8'd0) rel_cnt <= rel_cnt - 8'd1;
      low_cnt <= mem_we_n ? 8'd0 : low_cnt + 8'd1;
    end
  end

  // R1
  a_r1_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && mem_dq_oe == '0));
  // R2
  a_r2_busy_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !req_ready);
  // R3
  a_r3_valid_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_ce_n && !mem_oe_n && mem_we_n));
  // R5
  a_r5_release_window: assert property (@(posedge clk) disable iff (!rst_n)
    rel_window |-> (mem_dq_oe == '0 && mem_ce_n));
  // R6
  a_r6_we_excludes_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n));
  // R6
  a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (low_cnt == 8'(N_WP)));
  // R8
  a_r8_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_o) &&
                         $stable(mem_lb_n) && $stable(mem_ub_n) && !$past(mem_ce_n)));
  // R8
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_o) &&
                         $stable(mem_dq_oe) && !mem_ce_n));

  logic unused_ok;
  assign unused_ok = req_valid;
endmodule

bind sram_lane_ctrl sram_lane_chk #(
  .ADDR_W (ADDR_W),
  .LANES  (LANES),
  .N_WP   (N_WP),
  .N_REL  (N_REL)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .req_valid (req_valid),
  .rd_valid  (rd_valid),
  .mem_addr  (mem_addr),
  .mem_dq_o  (mem_dq_o),
  .mem_dq_oe (mem_dq_oe),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_lb_n  (mem_lb_n),
  .mem_ub_n  (mem_ub_n)
);

// File: tb/sim_sram_lane_ctrl.sv
`timescale 1ns/1ps
module sim_sram_lane_ctrl;
  localparam int CLK_NS = 8;
  localparam int T_ACC  = 70;
  localparam int T_WP   = 50;
  localparam int T_REL  = 40;

  function automatic int to_cyc(input int ns);
    int n;
    n = 0;
    while (n * CLK_NS < ns) n++;
    if (n == 0) n = 1;
    return n;
  endfunction

  localparam int E_RD  = to_cyc(T_ACC);
  localparam int E_WP  = to_cyc(T_WP);
  localparam int E_REL = to_cyc(T_REL);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rd_valid;
  logic [15:0] rd_data, mem_dq_o, mem_dq_i;
  logic [17:0] mem_addr;
  logic [1:0]  mem_dq_oe;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;

  always #4 clk = ~clk;

  sram_lane_ctrl #(.CLK_NS(CLK_NS), .T_ACC_NS(T_ACC), .T_WP_NS(T_WP), .T_REL_NS(T_REL)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
    .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n));

  int tests = 0, fails = 0, cyc = 0;
  int contention = 0;
  bit finished = 1'b0;

  // memory model: 256 words, floating lanes read as 8'hA5
  logic [15:0] mem [0:255];
  logic [15:0] shadow [0:255];
  logic [1:0]  mdrive;
  logic [1:0]  lane_n;
  assign lane_n = {mem_ub_n, mem_lb_n};

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      mdrive[l] = !mem_ce_n && mem_we_n && !mem_oe_n && !lane_n[l];
      mem_dq_i[8*l +: 8] = mdrive[l] ? mem[mem_addr[7:0]][8*l +: 8] : 8'hA5;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!mem_ce_n && !mem_we_n)
      for (int l = 0; l < 2; l++)
        if (!lane_n[l]) mem[mem_addr[7:0]][8*l +: 8] <= mem_dq_oe[l] ? mem_dq_o[8*l +: 8] : 8'h5A;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard
  typedef struct { logic [15:0] data; int due; } exp_t;
  exp_t rq[$];

  int we_low = 0, rel_left = 0;
  logic oe_prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin
        if (rq.size() == 0) check(1'b0, "R3 unexpected rd_valid", 1, 0);
        else begin
          exp_t e;
          e = rq.pop_front();
          check(rd_data == e.data, "R4 read data", rd_data, e.data);
          check(cyc == e.due, "R3 valid latency", cyc, e.due);
        end
      end
      if (mem_dq_oe & mdrive) contention++;
      if (!mem_we_n && !mem_oe_n) contention++;
      if (mem_oe_n && !oe_prev) rel_left = E_REL;
      if (rel_left > 0) begin
        if (mem_dq_oe != 2'b00 || !mem_ce_n) contention++;
        rel_left--;
      end
      oe_prev = mem_oe_n;
      if (!mem_we_n) we_low++;
      else if (we_low != 0) begin
        check(we_low == E_WP, "R6 write pulse width", we_low, E_WP);
        we_low = 0;
      end
    end
  end

  task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] be, output int acc);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk);
    @(negedge clk);
    acc = cyc;
    req_valid = 1'b0; req_wdata = 16'h0000; req_addr = '0;
  endtask

  task automatic wait_ready(input string req, input int expect_m);
    int m;
    m = 0;
    while (!req_ready) begin @(negedge clk); m++; end
    check(m == expect_m, req, m, expect_m);
  endtask

  task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    int acc;
    logic [15:0] w;
    w = shadow[a[7:0]];
    if (be[0]) w[7:0]  = d[7:0];
    if (be[1]) w[15:8] = d[15:8];
    shadow[a[7:0]] = w;
    issue(1'b1, a, d, be, acc);
    // setup cycle: lanes and drive per selected bytes, write enable still high (R7, R8)
    check(mem_addr == a && mem_dq_o == d, "R8 write address/data", mem_addr, a);
    check({mem_ub_n, mem_lb_n} == ~be && mem_dq_oe == be, "R7 write lanes",
          {mem_ub_n, mem_lb_n, mem_dq_oe}, {~be, be});
    check(mem_we_n && mem_oe_n && !mem_ce_n, "R6 setup cycle", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b011);
    wait_ready("R2 write occupancy", E_WP + 2);
  endtask

  task automatic do_read(input logic [17:0] a, input logic [1:0] be);
    int acc;
    exp_t e;
    logic [15:0] v;
    v = shadow[a[7:0]];
    e.data = {be[1] ? v[15:8] : 8'h00, be[0] ? v[7:0] : 8'h00};
    issue(1'b0, a, 16'h0, be, acc);
    e.due = acc + E_RD;
    rq.push_back(e);
    check(mem_addr == a, "R8 read address", mem_addr, a);
    check(!mem_ce_n && !mem_oe_n && mem_we_n && mem_dq_oe == 2'b00, "R3 read controls",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b00100);
    check({mem_ub_n, mem_lb_n} == ~be, "R4 read strobes", {mem_ub_n, mem_lb_n}, ~be);
    wait_ready("R2 read occupancy", E_RD + E_REL);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 16'h0000; shadow[i] = 16'h0000; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(req_ready && mem_ce_n && mem_oe_n && mem_we_n && mem_dq_oe == 2'b00 && !rd_valid,
          "R1 reset state", {req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid}, 7'b1111000);
    // R9 counts at 8 ns: 70->9, 50->7, 40->5 (also exercised by every latency check)
    check(E_RD == 9 && E_WP == 7 && E_REL == 5, "R9 derived counts", E_RD, 9);
    do_write(18'h00001, 16'h1234, 2'b11);
    do_write(18'h00002, 16'hABCD, 2'b11);
    do_read(18'h00001, 2'b11);
    do_read(18'h00002, 2'b11);
    // R7 lower lane only, upper kept
    do_write(18'h00001, 16'hFF77, 2'b01);
    do_read(18'h00001, 2'b11);
    // R7 upper lane only, lower kept
    do_write(18'h00002, 16'h9911, 2'b10);
    do_read(18'h00002, 2'b10);
    do_read(18'h00002, 2'b01);
    // R5 read directly followed by write
    do_read(18'h00001, 2'b11);
    do_write(18'h00003, 16'h5AA5, 2'b11);
    // top address (model index 8'hFF)
    do_write(18'h3FFFF, 16'hC3E1, 2'b11);
    do_read(18'h3FFFF, 2'b11);
    do_read(18'h00003, 2'b00);
    repeat (4) @(negedge clk);
    check(rq.size() == 0, "R3 all reads returned", rq.size(), 0);
    check(contention == 0, "R5 no bus overlap or drive in release window", contention, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule